// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block models the command front end of a parallel NOR flash. It watches single-cycle bus writes, each with an address and a 16-bit data value, and tracks multi-cycle command sequences: word/byte program, buffered program with a count and a closing confirm, block erase, setting and clearing of block lock bits, and protection-register program. For every sequence that completes correctly, it issues a one-cycle operation request, with kind, address, data and count, to the write engine outside the block. During a buffered program, each data cycle is also passed out as a push with its index, so that a buffer outside the block can store it.

The block holds one lock bit per block, a sequence-error flag and a lock-error flag. It also drives the status read path. The ready bit follows the write engine's busy input. While the engine is busy, only bit 7 of a status read is marked as driven. The memory array, operation timing and query data lie outside the block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, the read path is in array mode (`rd_oe_o` = 0), no request or push is pending, both error flags are clear and every lock bit is clear.
- R2: The opcode 0x40 and the opcode 0x10 each arm a program. The next write then raises `op_valid_o` for one cycle with kind 1 and that write's address and data. In byte mode the data is {8'h00, data[7:0]}.
- R3: Command writes decode only data[7:0]. In word mode, 0xAB40 arms a program in the same way as 0x40.
- R4: Opcode 0xE8 arms a buffered program and switches the read path to buffer status. Buffer status reads 0x0080 when the engine is idle, with bit 7 meaning "buffer available". The next write supplies the count N in data[7:0].
- R5: A count N that the block accepts is followed by exactly N+1 data writes. Each of these raises `buf_wr_o` one cycle later, with index 0 to N in order and that write's address and data.
- R6: No request is issued before the confirm. A 0xD0 write straight after the N+1 data writes issues kind 2 with the address of the 0xE8 write and `op_count_o` = N.
- R7: Any value other than 0xD0 in the confirm slot aborts the sequence. No request is issued, status bit 5 (sequence error) is set, the read path returns to array mode, and the decoder goes back to idle.
- R8: The count may be at most 0x0F in word mode and at most 0x1F in byte mode. A larger count aborts the sequence as in R7 and produces no pushes. A count of 0x1F in byte mode gives 32 pushes.
- R9: The sequence 0x60 then 0xD0, at any address, clears every lock bit. The sequence 0x60 then 0x01 sets the lock bit of the addressed block. The block index is wr_addr_i[15:13].
- R10: A program, erase or buffered program aimed at a locked block issues no request and sets status bit 1 (lock error). A buffered program is checked against the block of its 0xE8 address.
- R11: The sequence 0xC0 then an address/data write issues kind 4 with that address and data, whatever the lock bits hold.
- R12: The sequence 0x20 then 0xD0 issues kind 3 with the address of the 0xD0 write. Any other second value aborts the sequence as in R7.
- R13: In status mode, the status byte is {ready, 0, seq_err, 0, 0, 0, lock_err, 0}. When the engine is idle, `rd_oe_o` is 0x00FF in byte mode and 0xFFFF in word mode. When the engine is busy, `rd_oe_o` is 0x0080 and the data is 0. Opcode 0x70 selects status mode, 0xFF selects array mode, and 0x50 clears both error flags. The completion of any operation sequence selects status mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_mode_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| wr_en_i | input | 1 | One bus write in this cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 16 | Write data |
| wsm_busy_i | input | 1 | Write engine busy |
| op_valid_o | output | 1 | One-cycle operation request |
| op_kind_o | output | 3 | 1 program, 2 buffered, 3 erase, 4 protection |
| op_addr_o | output | ADDR_W | Request address |
| op_data_o | output | 16 | Request data |
| op_count_o | output | CNT_W | Buffered count N |
| buf_wr_o | output | 1 | Buffer push strobe |
| buf_idx_o | output | CNT_W | Push index |
| buf_addr_o | output | ADDR_W | Push address |
| buf_data_o | output | 16 | Push data |
| rd_data_o | output | 16 | Status read data |
| rd_oe_o | output | 16 | Per-bit driven mask |

## Verification
Requests, pushes, error flags and the read mode are registered. Each of them therefore changes on the clock edge that samples the write cycle which caused it, and is visible for the cycle after that edge. The read data and the driven mask also follow `wsm_busy_i` within the same cycle. The bench drives every write on a falling edge and holds it for one cycle. It samples one time unit after the next falling edge, which falls after the one rising edge that registers the result. Request pulses are counted on falling edges, so a request that must not appear is checked against that count rather than against a single sample.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PGM, S_PROT, S_BCNT, S_BDATA, S_BCONF, S_ERS, S_LOCK
  } seq_state_e;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_XSTAT} rd_mode_e;

  localparam logic [2:0] OP_NONE    = 3'd0;
  localparam logic [2:0] OP_PROGRAM = 3'd1;
  localparam logic [2:0] OP_BUFFER  = 3'd2;
  localparam logic [2:0] OP_ERASE   = 3'd3;
  localparam logic [2:0] OP_PROTECT = 3'd4;

  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_RD_STAT  = 8'h70;
  localparam logic [7:0] C_CLR_STAT = 8'h50;
  localparam logic [7:0] C_PGM_A    = 8'h40;
  localparam logic [7:0] C_PGM_B    = 8'h10;
  localparam logic [7:0] C_PROT     = 8'hC0;
  localparam logic [7:0] C_BUF      = 8'hE8;
  localparam logic [7:0] C_ERASE    = 8'h20;
  localparam logic [7:0] C_LOCK     = 8'h60;
  localparam logic [7:0] C_SET_LOCK = 8'h01;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;
endpackage

// File: rtl/fcd_buf_counter.sv
module fcd_buf_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic             last_o,
  output logic [CNT_W-1:0] idx_o
);
  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      idx_q    <= '0;
    end else if (load_i) begin
      remain_q <= load_val_i;
      idx_q    <= '0;
    end else if (step_i) begin
      remain_q <= remain_q - 1'b1;
      idx_q    <= idx_q + 1'b1;
    end
  end

  assign last_o = (remain_q == '0);
  assign idx_o  = idx_q;

  a_r5_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !last_o |=> idx_o == $past(idx_o) + 1'b1);
  a_r5_load_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> idx_o == '0);
endmodule

// File: rtl/fcd_lock_bank.sv
module fcd_lock_bank #(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_i,
  input  logic [BLK_W-1:0]      set_idx_i,
  input  logic                  clr_all_i,
  output logic [NUM_BLOCKS-1:0] lock_o
);
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_lock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   lock_o[b] <= 1'b0;
      else if (clr_all_i)                            lock_o[b] <= 1'b0;
      else if (set_i && set_idx_i == BLK_W'(b))      lock_o[b] <= 1'b1;
    end
  end

  a_r9_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> lock_o == '0);
  a_r9_set_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !clr_all_i |=> lock_o[$past(set_idx_i)]);
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_BLOCKS = 8,
  parameter int BUF_WORDS  = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(2 * BUF_WORDS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  word_mode_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [15:0]           wr_data_i,
  input  logic [NUM_BLOCKS-1:0] lock_i,
  input  logic                  cnt_last_i,
  input  logic [CNT_W-1:0]      cnt_idx_i,
  output logic                  cnt_load_o,
  output logic [CNT_W-1:0]      cnt_val_o,
  output logic                  cnt_step_o,
  output logic                  lock_set_o,
  output logic [BLK_W-1:0]      lock_idx_o,
  output logic                  lock_clr_o,
  output logic                  seq_err_o,
  output logic                  lock_err_o,
  output logic                  clr_stat_o,
  output logic                  mode_we_o,
  output rd_mode_e              mode_o,
  output logic                  op_valid_o,
  output logic [2:0]            op_kind_o,
  output logic [ADDR_W-1:0]     op_addr_o,
  output logic [15:0]           op_data_o,
  output logic [CNT_W-1:0]      op_count_o,
  output logic                  buf_wr_o,
  output logic [CNT_W-1:0]      buf_idx_o,
  output logic [ADDR_W-1:0]     buf_addr_o,
  output logic [15:0]           buf_data_o
);
  localparam logic [7:0] MAX_WORD = 8'(BUF_WORDS - 1);
  localparam logic [7:0] MAX_BYTE = 8'(2 * BUF_WORDS - 1);

  seq_state_e         st_q, st_d;
  logic [ADDR_W-1:0]  start_addr_q;
  logic [CNT_W-1:0]   n_q;
  logic [7:0]         cmd;
  logic [15:0]        wdat;
  logic [BLK_W-1:0]   q_blk;
  logic               q_locked;
  logic               fire;
  logic [2:0]         fire_kind;
  logic [ADDR_W-1:0]  fire_addr;
  logic [15:0]        fire_data;

  assign cmd        = wr_data_i[7:0];
  assign wdat       = word_mode_i ? wr_data_i : {8'h00, wr_data_i[7:0]};
  assign q_blk      = (st_q == S_BCONF) ? start_addr_q[ADDR_W-1 -: BLK_W]
                                        : wr_addr_i[ADDR_W-1 -: BLK_W];
  assign q_locked   = lock_i[q_blk];
  assign lock_idx_o = wr_addr_i[ADDR_W-1 -: BLK_W];
  assign cnt_val_o  = cmd[CNT_W-1:0];

  always_comb begin
    st_d       = st_q;
    cnt_load_o = 1'b0;
    cnt_step_o = 1'b0;
    lock_set_o = 1'b0;
    lock_clr_o = 1'b0;
    seq_err_o  = 1'b0;
    lock_err_o = 1'b0;
    clr_stat_o = 1'b0;
    mode_we_o  = 1'b0;
    mode_o     = RD_STATUS;
    fire       = 1'b0;
    fire_kind  = OP_NONE;
    fire_addr  = wr_addr_i;
    fire_data  = wdat;
    if (wr_en_i) begin
      unique case (st_q)
        S_IDLE: begin
          unique case (cmd)
            C_RD_ARRAY: begin mode_we_o = 1'b1; mode_o = RD_ARRAY; end
            C_RD_STAT:  mode_we_o = 1'b1;
            C_CLR_STAT: clr_stat_o = 1'b1;
            C_PGM_A, C_PGM_B: st_d = S_PGM;
            C_PROT:     st_d = S_PROT;
            C_BUF: begin
              st_d = S_BCNT; mode_we_o = 1'b1; mode_o = RD_XSTAT;
            end
            C_ERASE:    st_d = S_ERS;
            C_LOCK:     st_d = S_LOCK;
            default: ;
          endcase
        end
        S_PGM: begin
          st_d = S_IDLE; mode_we_o = 1'b1;
          if (q_locked) lock_err_o = 1'b1;
          else begin fire = 1'b1; fire_kind = OP_PROGRAM; end
        end
        S_PROT: begin
          st_d = S_IDLE; mode_we_o = 1'b1;
          fire = 1'b1; fire_kind = OP_PROTECT;
        end
        S_BCNT: begin
          if (cmd > (word_mode_i ? MAX_WORD : MAX_BYTE)) begin
            st_d = S_IDLE; seq_err_o = 1'b1; mode_we_o = 1'b1; mode_o = RD_ARRAY;
          end else begin
            st_d = S_BDATA; cnt_load_o = 1'b1;
          end
        end
        S_BDATA: begin
          cnt_step_o = 1'b1;
          if (cnt_last_i) st_d = S_BCONF;
        end
        S_BCONF, S_ERS: begin
          st_d = S_IDLE; mode_we_o = 1'b1;
          if (cmd != C_CONFIRM) begin
            seq_err_o = 1'b1; mode_o = RD_ARRAY;
          end else if (q_locked) begin
            lock_err_o = 1'b1;
          end else begin
            fire      = 1'b1;
            fire_data = '0;
            if (st_q == S_BCONF) begin
              fire_kind = OP_BUFFER; fire_addr = start_addr_q;
            end else begin
              fire_kind = OP_ERASE;
            end
          end
        end
        S_LOCK: begin
          st_d = S_IDLE; mode_we_o = 1'b1;
          if (cmd == C_CONFIRM)       lock_clr_o = 1'b1;
          else if (cmd == C_SET_LOCK) lock_set_o = 1'b1;
          else begin seq_err_o = 1'b1; mode_o = RD_ARRAY; end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      start_addr_q <= '0;
      n_q          <= '0;
      op_valid_o   <= 1'b0;
      op_kind_o    <= OP_NONE;
      op_addr_o    <= '0;
      op_data_o    <= '0;
      op_count_o   <= '0;
      buf_wr_o     <= 1'b0;
      buf_idx_o    <= '0;
      buf_addr_o   <= '0;
      buf_data_o   <= '0;
    end else begin
      st_q       <= st_d;
      op_valid_o <= fire;
      buf_wr_o   <= cnt_step_o;
      if (wr_en_i && st_q == S_IDLE && cmd == C_BUF) start_addr_q <= wr_addr_i;
      if (cnt_load_o) n_q <= cnt_val_o;
      if (fire) begin
        op_kind_o  <= fire_kind;
        op_addr_o  <= fire_addr;
        op_data_o  <= fire_data;
        op_count_o <= (fire_kind == OP_BUFFER) ? n_q : '0;
      end
      if (cnt_step_o) begin
        buf_idx_o  <= cnt_idx_i;
        buf_addr_o <= wr_addr_i;
        buf_data_o <= wdat;
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);
  a_r6_confirm_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_kind_o == OP_BUFFER |-> $past(wr_en_i) && $past(wr_data_i[7:0]) == C_CONFIRM);
  a_r10_not_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && op_kind_o == OP_PROGRAM
      |-> ($past(lock_i) & (NUM_BLOCKS'(1) << op_addr_o[ADDR_W-1 -: BLK_W])) == '0);
  a_r5_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> buf_idx_o <= n_q);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_BLOCKS = 8,
  parameter int BUF_WORDS  = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(2 * BUF_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic              wsm_busy_i,
  output logic              op_valid_o,
  output logic [2:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [15:0]       op_data_o,
  output logic [CNT_W-1:0]  op_count_o,
  output logic              buf_wr_o,
  output logic [CNT_W-1:0]  buf_idx_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [15:0]       buf_data_o,
  output logic [15:0]       rd_data_o,
  output logic [15:0]       rd_oe_o
);
  logic                  cnt_load, cnt_step, cnt_last;
  logic [CNT_W-1:0]      cnt_val, cnt_idx;
  logic                  lock_set, lock_clr;
  logic [BLK_W-1:0]      lock_idx;
  logic [NUM_BLOCKS-1:0] locks;
  logic                  seq_err_set, lock_err_set, clr_stat, mode_we;
  rd_mode_e              mode_d, mode_q;
  logic                  seq_err_q, lock_err_q;
  logic [7:0]            stat_byte, xstat_byte;
  logic [15:0]           full_mask;

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .NUM_BLOCKS(NUM_BLOCKS), .BUF_WORDS(BUF_WORDS)) u_fsm (
    .clk_i, .rst_ni, .word_mode_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .lock_i(locks), .cnt_last_i(cnt_last), .cnt_idx_i(cnt_idx),
    .cnt_load_o(cnt_load), .cnt_val_o(cnt_val), .cnt_step_o(cnt_step),
    .lock_set_o(lock_set), .lock_idx_o(lock_idx), .lock_clr_o(lock_clr),
    .seq_err_o(seq_err_set), .lock_err_o(lock_err_set), .clr_stat_o(clr_stat),
    .mode_we_o(mode_we), .mode_o(mode_d),
    .op_valid_o, .op_kind_o, .op_addr_o, .op_data_o, .op_count_o,
    .buf_wr_o, .buf_idx_o, .buf_addr_o, .buf_data_o
  );

  fcd_buf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(cnt_load), .load_val_i(cnt_val),
    .step_i(cnt_step), .last_o(cnt_last), .idx_o(cnt_idx)
  );

  fcd_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_locks (
    .clk_i, .rst_ni, .set_i(lock_set), .set_idx_i(lock_idx),
    .clr_all_i(lock_clr), .lock_o(locks)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= RD_ARRAY;
      seq_err_q  <= 1'b0;
      lock_err_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (clr_stat) begin
        seq_err_q  <= 1'b0;
        lock_err_q <= 1'b0;
      end else begin
        if (seq_err_set)  seq_err_q  <= 1'b1;
        if (lock_err_set) lock_err_q <= 1'b1;
      end
    end
  end

  assign stat_byte  = {~wsm_busy_i, 1'b0, seq_err_q, 3'b000, lock_err_q, 1'b0};
  assign xstat_byte = {~wsm_busy_i, 7'b0};
  assign full_mask  = word_mode_i ? 16'hFFFF : 16'h00FF;

  always_comb begin
    rd_data_o = '0;
    rd_oe_o   = '0;
    if (mode_q != RD_ARRAY) begin
      rd_oe_o = wsm_busy_i ? 16'h0080 : full_mask;
      if (!wsm_busy_i) rd_data_o = {8'h00, (mode_q == RD_XSTAT) ? xstat_byte : stat_byte};
    end
  end

  a_r7_seq_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_err_q) |-> $past(wr_en_i));
  a_r13_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stat |=> !seq_err_q && !lock_err_q);
  a_r10_lock_err_no_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_err_set |=> !op_valid_o);
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              word_mode = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [15:0]       wr_data = '0;
  logic              busy = 1'b0;
  logic              op_valid, buf_wr;
  logic [2:0]        op_kind;
  logic [ADDR_W-1:0] op_addr, buf_addr;
  logic [15:0]       op_data, buf_data, rd_data, rd_oe;
  logic [CNT_W-1:0]  op_count, buf_idx;

  int n_tests = 0;
  int n_fail  = 0;
  int op_cnt  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .word_mode_i(word_mode), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wsm_busy_i(busy),
    .op_valid_o(op_valid), .op_kind_o(op_kind), .op_addr_o(op_addr),
    .op_data_o(op_data), .op_count_o(op_count), .buf_wr_o(buf_wr),
    .buf_idx_o(buf_idx), .buf_addr_o(buf_addr), .buf_data_o(buf_data),
    .rd_data_o(rd_data), .rd_oe_o(rd_oe)
  );

  always @(negedge clk) if (op_valid) op_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic expect_op(input string req, input logic [2:0] k,
                           input logic [ADDR_W-1:0] a, input logic [15:0] d);
    check({req, " op_valid"}, op_valid, 1);
    check({req, " op_kind"},  op_kind, k);
    check({req, " op_addr"},  op_addr, a);
    check({req, " op_data"},  op_data, d);
  endtask

  task automatic t_reset();
    check("R1 rd_oe", rd_oe, 0);
    check("R1 op_valid", op_valid, 0);
    check("R1 buf_wr", buf_wr, 0);
    wr(0, 16'h0070);
    check("R1 status clean", rd_data, 16'h0080);
    wr(0, 16'h0040); wr(16'h4000, 16'h0101);
    expect_op("R1 no lock", 3'd1, 16'h4000, 16'h0101);
    wr(0, 16'h00FF);
  endtask

  task automatic t_program();
    word_mode = 1'b1;
    wr(0, 16'h0040);
    check("R2 setup no op", op_valid, 0);
    wr(16'h0123, 16'hBEEF);
    expect_op("R2 0x40", 3'd1, 16'h0123, 16'hBEEF);
    check("R13 status word", rd_data, 16'h0080);
    check("R13 oe word", rd_oe, 16'hFFFF);
    wr(0, 16'hAB40);
    wr(16'h0200, 16'h1234);
    expect_op("R3 upper ignored", 3'd1, 16'h0200, 16'h1234);
    word_mode = 1'b0;
    wr(0, 16'h0010);
    wr(16'h0300, 16'h12AB);
    expect_op("R2 0x10 byte", 3'd1, 16'h0300, 16'h00AB);
    check("R13 oe byte", rd_oe, 16'h00FF);
    word_mode = 1'b1;
  endtask

  task automatic t_buffer();
    int ops0;
    wr(16'h2000, 16'h00E8);
    check("R4 xstat data", rd_data, 16'h0080);
    check("R4 xstat oe", rd_oe, 16'hFFFF);
    busy = 1'b1; #1;
    check("R13 busy oe", rd_oe, 16'h0080);
    check("R13 busy data", rd_data, 16'h0000);
    busy = 1'b0; #1;
    ops0 = op_cnt;
    wr(16'h2000, 16'h0003);
    for (int i = 0; i < 4; i++) begin
      wr(16'h2000 + 16'(i), 16'hA000 + 16'(i));
      check("R5 push", buf_wr, 1);
      check("R5 idx", buf_idx, i);
      check("R5 addr", buf_addr, 16'h2000 + i);
      check("R5 data", buf_data, 16'hA000 + i);
    end
    check("R6 no early op", op_cnt, ops0);
    wr(16'h2000, 16'h00D0);
    expect_op("R6 confirm", 3'd2, 16'h2000, 16'h0000);
    check("R6 count", op_count, 3);
  endtask

  task automatic t_abort();
    int ops0;
    ops0 = op_cnt;
    wr(16'h2000, 16'h00E8);
    wr(16'h2000, 16'h0001);
    wr(16'h2000, 16'h1111);
    wr(16'h2001, 16'h2222);
    wr(16'h2000, 16'h0040);
    check("R7 array mode", rd_oe, 0);
    wr(16'h0123, 16'hBEEF);
    check("R7 no op", op_cnt, ops0);
    wr(0, 16'h0070);
    check("R7 seq err", rd_data, 16'h00A0);
    wr(0, 16'h0050);
    check("R13 clear", rd_data, 16'h0080);
  endtask

  task automatic t_count();
    int ops0;
    word_mode = 1'b1;
    wr(0, 16'h00E8);
    wr(0, 16'h0010);
    check("R8 word over", rd_oe, 0);
    wr(0, 16'h5555);
    check("R8 no push", buf_wr, 0);
    wr(0, 16'h0070);
    check("R8 seq err", rd_data, 16'h00A0);
    wr(0, 16'h0050);
    word_mode = 1'b0;
    wr(16'h1000, 16'h00E8);
    wr(16'h1000, 16'h001F);
    for (int i = 0; i < 32; i++) begin
      wr(16'h1000 + 16'(i), 16'(i));
      check("R8 byte max push", buf_idx, i);
    end
    wr(16'h1000, 16'h00D0);
    expect_op("R8 byte max", 3'd2, 16'h1000, 16'h0000);
    check("R8 byte count", op_count, 31);
    ops0 = op_cnt;
    wr(0, 16'h00E8);
    wr(0, 16'h0020);
    wr(0, 16'h0070);
    check("R8 byte over", rd_data, 16'h00A0);
    check("R8 no op", op_cnt, ops0);
    wr(0, 16'h0050);
    word_mode = 1'b1;
  endtask

  task automatic t_lock();
    int ops0;
    wr(16'h4000, 16'h0060); wr(16'h4000, 16'h0001);
    ops0 = op_cnt;
    wr(0, 16'h0040); wr(16'h4010, 16'h1111);
    check("R10 program blocked", op_cnt, ops0);
    check("R10 lock err", rd_data, 16'h0082);
    wr(16'h4000, 16'h0020); wr(16'h4000, 16'h00D0);
    check("R10 erase blocked", op_cnt, ops0);
    wr(16'h4000, 16'h00E8); wr(16'h4000, 16'h0000);
    wr(16'h4002, 16'h7777); wr(16'h4000, 16'h00D0);
    check("R10 buffer blocked", op_cnt, ops0);
    wr(0, 16'h0040); wr(16'h6000, 16'h2222);
    expect_op("R9 other block", 3'd1, 16'h6000, 16'h2222);
    wr(0, 16'h0050);
    wr(16'h1234, 16'h0060); wr(16'h1234, 16'h00D0);
    wr(0, 16'h0040); wr(16'h4010, 16'h3333);
    expect_op("R9 cleared", 3'd1, 16'h4010, 16'h3333);
    check("R9 status", rd_data, 16'h0080);
  endtask

  task automatic t_protect();
    int ops0;
    wr(0, 16'h0060); wr(0, 16'h0001);
    wr(0, 16'h00C0); wr(16'h0003, 16'h5555);
    expect_op("R11 protect", 3'd4, 16'h0003, 16'h5555);
    ops0 = op_cnt;
    wr(0, 16'h0040); wr(16'h0005, 16'h6666);
    check("R10 blk0 locked", op_cnt, ops0);
    wr(0, 16'h0050);
    wr(0, 16'h0060); wr(0, 16'h00D0);
  endtask

  task automatic t_erase();
    int ops0;
    wr(16'hE000, 16'h0020); wr(16'hE000, 16'h00D0);
    expect_op("R12 erase", 3'd3, 16'hE000, 16'h0000);
    ops0 = op_cnt;
    wr(16'hE000, 16'h0020); wr(16'hE000, 16'h0030);
    check("R12 abort array", rd_oe, 0);
    check("R12 no op", op_cnt, ops0);
    wr(0, 16'h0070);
    check("R12 seq err", rd_data, 16'h00A0);
    wr(0, 16'h0050);
    wr(0, 16'h00FF);
    check("R13 array", rd_oe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_program();
    t_buffer();
    t_abort();
    t_count();
    t_lock();
    t_protect();
    t_erase();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule